// File: doc/BRIEF.md
# Tenths-Resolution BCD Stopwatch

This block is a synchronous stopwatch built from three BCD digits chained by their carries. The lowest digit counts tenths of a second, the middle digit counts seconds, and the top digit counts tens of seconds modulo 6. The display therefore runs from 00.0 to 59.9 and then returns to 00.0. A prescaler driven by the single fast clock makes the counting tick. Its period is a parameter. A speed-select input stretches that period ten times, so the tenths digit then steps once per second. A pause input stops the tick.

Two decoded strobes come out with the digits. The first is a one-cycle pulse on each tick that rolls the tenths digit over, which gives one pulse per second at normal speed. The second is an alert on the tick that leaves 29.9 or 59.9, which marks each half minute. An active-low clear zeroes the display. An active-low preset loads 1 into every digit, so the display reads 11.1. Both act on the next clock edge, also while the block is paused.

Top module: `bcd_stopwatch`

## Requirements
- R1: With speed-select low and pause low, the tick comes once every TICK_CYCLES clock cycles. Each tick advances the tenths digit (`tenths_o`, binary value 0..9) by one, and 9 goes to 0.
- R2: The seconds digit (`secs_o`) advances only on a tick that finds the tenths digit at 9. It counts 0..9 and wraps.
- R3: The tens digit (`tens_o`) advances only when that carry also finds the seconds digit at 9. It never exceeds 5, and the tick after 59.9 gives 00.0.
- R4: When `clear_n` is low, all three digits are 0 after the next clock edge. This holds whether or not the block is paused, and clear wins over preset.
- R5: When `preset_n` is low and `clear_n` is high, all three digits are 1 (11.1) after the next clock edge. This holds whether or not the block is paused, and preset wins over counting.
- R6: `sec_pulse_o` is high exactly in the cycles where a tick occurs while the tenths digit is 9.
- R7: `half_min_o` is high exactly in the tick cycles where the display reads 29.9 or 59.9.
- R8: With speed-select high, the tick period is TICK_CYCLES × SLOW_FACTOR clock cycles.
- R9: While `pause` is high, no tick occurs and the digits and the prescaler phase hold their values.
- R10: In a cycle where the speed-select input differs from its value at the previous edge, no tick occurs and the prescaler restarts from zero. The next tick then comes one full period of the new mode later.
- R11: While `rst_n` is low, all digits are 0, the prescaler is at phase zero in normal mode, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_n | input | 1 | Synchronous active-low clear of the display to 00.0 |
| preset_n | input | 1 | Synchronous active-low load of 11.1 |
| pause | input | 1 | Holds the prescaler and the digits while high |
| slow | input | 1 | Selects the tick period that is SLOW_FACTOR times longer |
| tenths_o | output | 4 | Tenths digit, BCD |
| secs_o | output | 4 | Seconds digit, BCD |
| tens_o | output | 4 | Tens-of-seconds digit, BCD 0..5 |
| sec_pulse_o | output | 1 | Tick that rolls the tenths digit over |
| half_min_o | output | 1 | Tick leaving 29.9 or 59.9 |

## Verification
The counter first runs free through more than one full 600-tick cycle with a short prescaler. Every display value, both carry boundaries and the wrap after 59.9 are compared with a model that keeps the time as a single integer in tenths, so any fault in the carry chain or the modulo-6 digit shows up. Separate phases pause the count, clear and preset it while paused, and assert both together. These phases separate a hold fault from a priority fault. A slow-mode run and rapid toggles of the speed select check the stretched period and the restart of the prescaler. These two checks tell an early or doubled tick apart from a correct one.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 3;

  // Modulus of each digit position: tenths and seconds are decimal, tens is 0..5.
  function automatic int digit_modulus(input int idx);
    return (idx == NUM_DIGITS - 1) ? 6 : 10;
  endfunction

  // Next value of a digit with the given modulus.
  function automatic logic [DIGIT_W-1:0] digit_next(input logic [DIGIT_W-1:0] d,
                                                     input int modulus);
    logic [DIGIT_W-1:0] top;
    top = DIGIT_W'(modulus - 1);
    return (d == top) ? '0 : d + DIGIT_W'(1);
  endfunction

  // True when the digit sits at its last value.
  function automatic logic digit_at_top(input logic [DIGIT_W-1:0] d, input int modulus);
    return d == DIGIT_W'(modulus - 1);
  endfunction

  // Tens values that raise the half-minute alert.
  function automatic logic alert_tens(input logic [DIGIT_W-1:0] t);
    return (t == DIGIT_W'(2)) || (t == DIGIT_W'(5));
  endfunction
endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int TICK_CYCLES = 25_000_000,
  parameter int SLOW_FACTOR = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause,
  input  logic slow,
  output logic tick
);
  localparam int LIM_FAST = TICK_CYCLES;
  localparam int LIM_SLOW = TICK_CYCLES * SLOW_FACTOR;
  localparam int CW       = $clog2(LIM_SLOW + 1);
  localparam logic [CW-1:0] LAST_FAST = CW'(LIM_FAST - 1);
  localparam logic [CW-1:0] LAST_SLOW = CW'(LIM_SLOW - 1);

  logic [CW-1:0] phase;
  logic          slow_q;
  logic [CW-1:0] last;
  logic          mode_change;

  assign last        = slow_q ? LAST_SLOW : LAST_FAST;
  assign mode_change = slow != slow_q;
  assign tick        = !pause && !mode_change && (phase == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      slow_q <= 1'b0;
    end else if (mode_change) begin
      slow_q <= slow;
      phase  <= '0;
    end else if (!pause) begin
      phase <= (phase == last) ? '0 : phase + CW'(1);
    end
  end
endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import sw_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load,
  input  logic [DIGIT_W-1:0] load_val,
  input  logic               en,
  output logic [DIGIT_W-1:0] q,
  output logic               carry
);
  assign carry = en && digit_at_top(q, MODULUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (load)   q <= load_val;
    else if (en)     q <= digit_next(q, MODULUS);
  end
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch
  import sw_pkg::*;
#(
  parameter int TICK_CYCLES = 25_000_000,
  parameter int SLOW_FACTOR = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_n,
  input  logic       preset_n,
  input  logic       pause,
  input  logic       slow,
  output logic [3:0] tenths_o,
  output logic [3:0] secs_o,
  output logic [3:0] tens_o,
  output logic       sec_pulse_o,
  output logic       half_min_o
);
  localparam logic [DIGIT_W-1:0] PRESET_VAL = DIGIT_W'(1);

  logic                             tick_w;
  logic [NUM_DIGITS:0]              en_chain;
  logic [NUM_DIGITS-1:0]            carry_w;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digs;

  sw_tick_gen #(.TICK_CYCLES(TICK_CYCLES), .SLOW_FACTOR(SLOW_FACTOR)) u_tick (
    .clk(clk), .rst_n(rst_n), .pause(pause), .slow(slow), .tick(tick_w)
  );

  assign en_chain[0] = tick_w;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    sw_digit #(.MODULUS(digit_modulus(i))) u_d (
      .clk(clk), .rst_n(rst_n),
      .clr(!clear_n), .load(!preset_n), .load_val(PRESET_VAL),
      .en(en_chain[i]), .q(digs[i]), .carry(carry_w[i])
    );
    assign en_chain[i+1] = carry_w[i];
  end

  assign tenths_o    = digs[0];
  assign secs_o      = digs[1];
  assign tens_o      = digs[2];
  assign sec_pulse_o = carry_w[0];
  assign half_min_o  = carry_w[1] && alert_tens(digs[2]);
endmodule

// File: rtl/sw_chk.sv
module sw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clear_n,
  input logic       preset_n,
  input logic       pause,
  input logic       tick,
  input logic       carry_t,
  input logic [3:0] tenths,
  input logic [3:0] secs,
  input logic [3:0] tens,
  input logic       sec_pulse,
  input logic       half_min
);
  // R3
  tens_range_chk: assert property (@(posedge clk) disable iff (!rst_n) tens <= 4'd5);
  // R2
  secs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(secs) |-> ($past(carry_t) || !$past(clear_n) || !$past(preset_n)));
  // R9
  pause_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) pause |-> !tick);
  // R6
  pulse_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (tick && tenths == 4'd9));
  // R7
  alert_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_min |-> (sec_pulse && secs == 4'd9 && (tens == 4'd2 || tens == 4'd5)));
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (tenths == 4'd0 && secs == 4'd0 && tens == 4'd0));
  // R5
  preset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !preset_n) |=> (tenths == 4'd1 && secs == 4'd1 && tens == 4'd1));
endmodule

bind bcd_stopwatch sw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .preset_n(preset_n), .pause(pause),
  .tick(tick_w), .carry_t(carry_w[0]),
  .tenths(tenths_o), .secs(secs_o), .tens(tens_o),
  .sec_pulse(sec_pulse_o), .half_min(half_min_o)
);

// File: tb/sim_bcd_stopwatch.sv
`timescale 1ns/1ps
module sim_bcd_stopwatch;
  localparam int TC = 2;
  localparam int SF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clear_n = 1'b1, preset_n = 1'b1, pause = 1'b0, slow = 1'b0;
  logic [3:0] tenths_o, secs_o, tens_o;
  logic sec_pulse_o, half_min_o;

  int n_checks = 0, n_fail = 0;
  int m_val = 0, m_cnt = 0;
  bit m_sq = 1'b0, m_tick;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_stopwatch #(.TICK_CYCLES(TC), .SLOW_FACTOR(SF)) u0 (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .preset_n(preset_n),
    .pause(pause), .slow(slow), .tenths_o(tenths_o), .secs_o(secs_o), .tens_o(tens_o),
    .sec_pulse_o(sec_pulse_o), .half_min_o(half_min_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lim(input bit s);
    return s ? TC * SF : TC;
  endfunction

  task automatic chk_digits(input string tag);
    int act;
    act = 100 * int'(tens_o) + 10 * int'(secs_o) + int'(tenths_o);
    chk(tenths_o == 4'(m_val % 10) && secs_o == 4'((m_val / 10) % 10) &&
        tens_o == 4'(m_val / 100), tag, act, m_val);
  endtask

  // Inputs are set after a falling edge; one clock is applied and checked.
  task automatic step(input string tag);
    #1;
    m_tick = !pause && (slow == m_sq) && (m_cnt == lim(m_sq) - 1);
    chk(sec_pulse_o == (m_tick && (m_val % 10 == 9)), "R6 pulse", int'(sec_pulse_o),
        int'(m_tick && (m_val % 10 == 9)));
    chk(half_min_o == (m_tick && (m_val == 299 || m_val == 599)), "R7 alert",
        int'(half_min_o), int'(m_tick && (m_val == 299 || m_val == 599)));
    @(posedge clk);
    if (slow != m_sq) begin m_sq = slow; m_cnt = 0; end
    else if (!pause) m_cnt = (m_cnt == lim(m_sq) - 1) ? 0 : m_cnt + 1;
    if (!clear_n)       m_val = 0;
    else if (!preset_n) m_val = 111;
    else if (m_tick)    m_val = (m_val + 1) % 600;
    @(negedge clk);
    chk_digits(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk_digits("R11 reset digits");
    chk(!sec_pulse_o && !half_min_o, "R11 reset strobes",
        int'(sec_pulse_o) + int'(half_min_o), 0);
    rst_n = 1'b1;
    // R1 R2 R3: free run past the 59.9 wrap
    run(1250, "R1 R2 R3 count");
    // R9: pause holds
    pause = 1'b1;
    run(20, "R9 pause");
    // R4: clear while paused
    clear_n = 1'b0; step("R4 clear paused"); clear_n = 1'b1;
    run(3, "R9 hold after clear");
    // R5: preset while paused, then R4 priority
    preset_n = 1'b0; step("R5 preset paused");
    clear_n = 1'b0; step("R4 clear over preset");
    clear_n = 1'b1; preset_n = 1'b1; pause = 1'b0;
    run(30, "R1 after clear");
    // R5: preset beats counting
    preset_n = 1'b0; run(4, "R5 preset over count"); preset_n = 1'b1;
    run(50, "R5 count from preset");
    // R8: slow mode
    slow = 1'b1; run(250, "R8 slow");
    // R10: mode changes restart the prescaler
    slow = 1'b0; run(1, "R10 switch"); run(5, "R10 fast");
    slow = 1'b1; run(7, "R10 slow part");
    slow = 1'b0; step("R10 switch back");
    slow = 1'b1; step("R10 toggle");
    slow = 1'b0; run(40, "R10 fast resume");
    // R3: run again to the alert points and wrap
    run(1300, "R3 R7 second lap");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule